// File: doc/BRIEF.md
# Pulse-Stepped Saturating DAC Code Counter

This block holds the 5-bit code that sets a voltage DAC. Two push inputs move the code, one step per push. The block reacts to the rising edges of these inputs, not to their levels. Both push inputs are asynchronous, so each one passes through a two-flop synchroniser and then a one-cycle rising-edge detector. The code saturates at zero and at full scale and never wraps.

Holding both push inputs high together, a chord, returns the code to mid-scale. A polarity input swaps the roles of the two inputs. With it, a push on a given input moves the output magnitude the same way whatever the sign of the output.

A shutdown level freezes the code: pushes and chords are ignored while it is high. An undervoltage level and the power-on reset both force mid-scale, and they override everything else. Flags mark the zero code and the full-scale code. The shutdown and undervoltage levels are taken as synchronous to the block clock.

Top module: `dac_step_counter`

## Requirements
- R1: With polarityNeg low, a rising edge on pushUp lowers the code by one and a rising edge on pushDn raises it by one.
- R2: With polarityNeg high, the roles are swapped: a rising edge on pushUp raises the code by one and a rising edge on pushDn lowers it by one.
- R3: The code never wraps. A lowering step at code 0 leaves it at 0, and a raising step at code 31 leaves it at 31.
- R4: While both synchronised push inputs are high, shutdown is low and underVolt is low, the code is forced to mid-scale, 16 (binary 10000).
- R5: A rising edge on one input while the other input is already high takes no step, because the chord has priority. After a chord, no step is taken until an input has gone low and risen again.
- R6: While shutdown is high and underVolt is low, the code holds its value. Edges and chords are ignored. An input that is still held high when shutdown is released takes no step.
- R7: While rstN is low, or in the cycle after underVolt is sampled high, the code is 16. This has priority over every other input.
- R8: atZero is high exactly when the code is 0, and atFull is high exactly when the code is 31.
- R9: A push that rises between clock edges changes the code at the third rising clock edge after the rise. Each push gives at most one step, however long it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous power-on reset; loads mid-scale |
| pushUp | input | 1 | Asynchronous push input, first direction |
| pushDn | input | 1 | Asynchronous push input, second direction |
| polarityNeg | input | 1 | High for negative output; swaps the step directions |
| shutdown | input | 1 | High freezes the code |
| underVolt | input | 1 | High forces mid-scale |
| code | output | 5 | DAC code |
| atZero | output | 1 | High when the code is 0 |
| atFull | output | 1 | High when the code is 31 |

## Verification
Several functions can act in the same cycle, and the priority between them is the risk. A step edge can coincide with a chord, and a chord can coincide with shutdown or with undervoltage. The bench provokes these cases in two ways: it raises one input while the other is already held high, and it raises both inputs together inside a shutdown or undervoltage window. A behavioural model ranks these cases as undervoltage, then freeze, then chord, then step. It judges every cycle by comparing the code and the flags against that model. Directed checks then confirm the final codes after each case.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  // Strobes from the control to the code register; at most one is high.
  typedef struct packed {
    logic loadMid;
    logic stepInc;
    logic stepDec;
  } stepCmd_t;
endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
  parameter int CHANNELS = 2,
  parameter int STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CHANNELS-1:0] rawIn,
  output logic [CHANNELS-1:0] level,
  output logic [CHANNELS-1:0] rise
);
  localparam int LAST = STAGES - 1;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : gChan
    logic [STAGES-1:0] chain;
    logic prevQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain <= '0;
        prevQ <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], rawIn[ch]};
        prevQ <= chain[LAST];
      end
    end

    assign level[ch] = chain[LAST];
    assign rise[ch]  = chain[LAST] & ~prevQ;

    // R9: a held input yields one detected edge only
    assert_rise_single_R9: assert property (@(posedge clk) disable iff (!rstN)
      rise[ch] |=> !rise[ch]);
  end
endmodule

// File: rtl/dsc_control.sv
module dsc_control
  import dsc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     upLevel,
  input  logic     dnLevel,
  input  logic     upRise,
  input  logic     dnRise,
  input  logic     polarityNeg,
  input  logic     shutdown,
  input  logic     underVolt,
  output stepCmd_t cmd
);
  logic chord;
  logic incReq;
  logic decReq;
  logic stepAllowed;

  always_comb begin
    chord       = upLevel & dnLevel;
    incReq      = polarityNeg ? upRise : dnRise;
    decReq      = polarityNeg ? dnRise : upRise;
    stepAllowed = ~underVolt & ~shutdown & ~chord;
    cmd.loadMid = underVolt | (~shutdown & chord);
    cmd.stepInc = stepAllowed & incReq & ~decReq;
    cmd.stepDec = stepAllowed & decReq & ~incReq;
  end

  // R5: chord and stepping never act together
  assert_strobes_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.loadMid, cmd.stepInc, cmd.stepDec}));

  // R6: no strobe reaches the register during a freeze
  assert_freeze_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (shutdown && !underVolt) |-> !(cmd.loadMid || cmd.stepInc || cmd.stepDec));
endmodule

// File: rtl/dsc_datapath.sv
module dsc_datapath
  import dsc_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCmd_t          cmd,
  output logic [CODE_W-1:0] code,
  output logic              atZero,
  output logic              atFull
);
  localparam logic [CODE_W-1:0] MID_CODE  = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] FULL_CODE = '1;
  localparam logic [CODE_W-1:0] ZERO_CODE = '0;

  logic [CODE_W-1:0] codeNext;

  always_comb begin
    codeNext = code;
    if (cmd.loadMid)
      codeNext = MID_CODE;
    else if (cmd.stepInc && code != FULL_CODE)
      codeNext = code + CODE_W'(1);
    else if (cmd.stepDec && code != ZERO_CODE)
      codeNext = code - CODE_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) code <= MID_CODE;
    else       code <= codeNext;
  end

  assign atZero = (code == ZERO_CODE);
  assign atFull = (code == FULL_CODE);

  // R3: no jump across the ends of the range
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(code) == FULL_CODE) |-> (code != ZERO_CODE));
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(code) == ZERO_CODE) |-> (code != FULL_CODE));

  // R1: any change is a single step or a return to mid-scale
  assert_unit_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (code != $past(code)) |-> (code == MID_CODE || code == $past(code) + CODE_W'(1)
                               || code == $past(code) - CODE_W'(1)));

  // R8: the two end flags are never high together
  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({atZero, atFull}));
endmodule

// File: rtl/dac_step_counter.sv
module dac_step_counter
  import dsc_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushUp,
  input  logic              pushDn,
  input  logic              polarityNeg,
  input  logic              shutdown,
  input  logic              underVolt,
  output logic [CODE_W-1:0] code,
  output logic              atZero,
  output logic              atFull
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [1:0] syncLevel;
  logic [1:0] syncRise;
  stepCmd_t   cmd;

  dsc_sync #(.CHANNELS(2), .STAGES(SYNC_STAGES)) uSync (
    .clk   (clk),
    .rstN  (rstN),
    .rawIn ({pushDn, pushUp}),
    .level (syncLevel),
    .rise  (syncRise)
  );

  dsc_control uControl (
    .clk         (clk),
    .rstN        (rstN),
    .upLevel     (syncLevel[0]),
    .dnLevel     (syncLevel[1]),
    .upRise      (syncRise[0]),
    .dnRise      (syncRise[1]),
    .polarityNeg (polarityNeg),
    .shutdown    (shutdown),
    .underVolt   (underVolt),
    .cmd         (cmd)
  );

  dsc_datapath #(.CODE_W(CODE_W)) uDatapath (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .code   (code),
    .atZero (atZero),
    .atFull (atFull)
  );

  // R7: undervoltage lands the code on mid-scale
  assert_uv_mid_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(underVolt) |-> (code == MID_CODE));

  // R6: the code is frozen while shut down
  assert_shutdown_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(shutdown) && !$past(underVolt)) |-> $stable(code));

  // R4: a chord outside shutdown lands on mid-scale
  assert_chord_mid_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(syncLevel[0] && syncLevel[1]) && !$past(shutdown)) |-> (code == MID_CODE));
endmodule

// File: tb/dac_step_counter_test.sv
module dac_step_counter_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushUp = 1'b0, pushDn = 1'b0, polarityNeg = 1'b0;
  logic shutdown = 1'b0, underVolt = 1'b0;
  logic [4:0] code;
  logic atZero, atFull;

  int testsRun = 0;
  int testsFailed = 0;
  string phase = "R7";
  bit done = 0;

  int mCode = 16;
  int u1 = 0, u2 = 0, u3 = 0, d1 = 0, d2 = 0, d3 = 0;

  dac_step_counter uut (
    .clk(clk), .rstN(rstN), .pushUp(pushUp), .pushDn(pushDn),
    .polarityNeg(polarityNeg), .shutdown(shutdown), .underVolt(underVolt),
    .code(code), .atZero(atZero), .atFull(atFull)
  );

  always #2 clk = ~clk;

  // Behavioural reference: sampled history of each input, priority ranking
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCode = 16; u1 = 0; u2 = 0; u3 = 0; d1 = 0; d2 = 0; d3 = 0;
    end else begin
      bit upEdge, dnEdge, both;
      upEdge = (u2 == 1) && (u3 == 0);
      dnEdge = (d2 == 1) && (d3 == 0);
      both = (u2 == 1) && (d2 == 1);
      if (underVolt) mCode = 16;
      else if (shutdown) mCode = mCode;
      else if (both) mCode = 16;
      else if (upEdge != dnEdge) begin
        if ((upEdge && !polarityNeg) || (dnEdge && polarityNeg)) begin
          if (mCode > 0) mCode = mCode - 1;
        end else begin
          if (mCode < 31) mCode = mCode + 1;
        end
      end
      u3 = u2; u2 = u1; u1 = pushUp;
      d3 = d2; d2 = d1; d1 = pushDn;
    end
  end

  task automatic check(string tag, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check({phase, " code"}, int'(code), mCode);
      check("R8 atZero", int'(atZero), int'(mCode == 0));
      check("R8 atFull", int'(atFull), int'(mCode == 31));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseUp();
    @(negedge clk); pushUp = 1'b1; idle(4); pushUp = 1'b0; idle(4);
  endtask

  task automatic pulseDn();
    @(negedge clk); pushDn = 1'b1; idle(4); pushDn = 1'b0; idle(4);
  endtask

  task automatic chord();
    @(negedge clk); pushUp = 1'b1; pushDn = 1'b1; idle(5);
    pushUp = 1'b0; pushDn = 1'b0; idle(5);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    idle(2);
    check("R7 reset code", int'(code), 16);
    check("R8 reset flags", int'({atZero, atFull}), 0);
    rstN = 1'b1;
    idle(2);

    // R9 latency: change at the third edge after the rise
    phase = "R9";
    @(negedge clk); pushDn = 1'b1;
    idle(2); check("R9 before third edge", int'(code), 16);
    idle(1); check("R9 at third edge", int'(code), 17);
    idle(6); check("R9 one step per push", int'(code), 17);
    pushDn = 1'b0; idle(4);

    phase = "R1";
    pulseDn(); pulseDn();
    check("R1 DN raises", int'(code), 19);
    pulseUp();
    check("R1 UP lowers", int'(code), 18);

    phase = "R3";
    for (int i = 0; i < 16; i++) pulseDn();
    check("R3 top saturate", int'(code), 31);
    check("R8 atFull", int'(atFull), 1);

    phase = "R4";
    chord();
    check("R4 chord mid", int'(code), 16);

    phase = "R3";
    for (int i = 0; i < 18; i++) pulseUp();
    check("R3 bottom saturate", int'(code), 0);
    check("R8 atZero", int'(atZero), 1);

    phase = "R2";
    polarityNeg = 1'b1;
    pulseUp(); pulseUp();
    check("R2 UP raises", int'(code), 2);
    pulseDn();
    check("R2 DN lowers", int'(code), 1);

    // R5: edge on DN while UP held is a chord, not a step
    phase = "R5";
    @(negedge clk); pushUp = 1'b1; idle(5);
    check("R5 lone UP steps", int'(code), 2);
    pushDn = 1'b1; idle(5);
    check("R5 chord over edge", int'(code), 16);
    pushDn = 1'b0; idle(5);
    check("R5 no step after chord", int'(code), 16);
    pushUp = 1'b0; idle(4);
    pulseUp();
    check("R5 re-rise steps", int'(code), 17);

    // R6: freeze
    phase = "R6";
    @(negedge clk); shutdown = 1'b1;
    pulseUp(); pulseDn(); chord();
    check("R6 frozen", int'(code), 17);
    @(negedge clk); pushUp = 1'b1; idle(5);
    shutdown = 1'b0; idle(5);
    check("R6 held input no step", int'(code), 17);
    pushUp = 1'b0; idle(4);

    // R7: undervoltage with pushes and shutdown together
    phase = "R7";
    polarityNeg = 1'b0;
    pulseDn(); pulseDn();
    check("R7 setup", int'(code), 19);
    @(negedge clk); underVolt = 1'b1; shutdown = 1'b1;
    idle(1); check("R7 uv over shutdown", int'(code), 16);
    shutdown = 1'b0;
    pulseDn(); pulseUp();
    check("R7 uv holds mid", int'(code), 16);
    underVolt = 1'b0; idle(2);
    pulseUp();
    check("R7 after uv", int'(code), 15);

    @(negedge clk); rstN = 1'b0; idle(1);
    check("R7 async reset", int'(code), 16);
    rstN = 1'b1; idle(3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule